// File: doc/BRIEF.md
# Token-Owned Half-Duplex Link Port

This controller sits at one end of a byte-wide, point-to-point link that carries data in one direction at a time. A single token decides the direction. The side holding the receiver role drives two active-low lines toward the far end: a request line and a ready line. It reads three things from the far end: an active-low strobe, an active-low acknowledge and an eight-bit data bus. Each word moves with a four-phase handshake. The sender pulls strobe low while the byte is valid. The receiver answers by pulling ready low and lets it go again once strobe returns high.

To send, the local user raises `tx_valid` while the port is in the receiver role. The port then pulls request low. When the far end answers with acknowledge low, the port drives request high for one cycle to acknowledge the exchange. It then stops driving request and ready, and starts driving acknowledge and strobe high. After a parameterised gap it begins driving the data bus, and then sends bytes.

The token goes back the other way when the far end pulls request low while this side is idle in the sender role. Every pin is modelled as a separate input, output value and output enable, so the pad ring decides how to build the tristate. All link inputs pass through synchronizer stages before any decision is made on them.

Top module: `tpl_link_port`

## Requirements
- R1: A synchronous active-high reset puts the port in the receiver role. In that state request and ready are enabled and driven high, the acknowledge, strobe and data enables are low, and `rx_valid` and `tx_taken` are low.
- R2: In the receiver role, with no word in progress, the request output is driven low for as long as `tx_valid` is high.
- R3: A strobe-low input in the receiver role drives ready low exactly SYNC_STAGES+1 cycles later. In that same cycle `rx_valid` pulses for one cycle, and `rx_data` carries the byte that was on the data inputs. Ready goes high again SYNC_STAGES+1 cycles after strobe returns high.
- R4: An acknowledge-low input while a request is pending takes SYNC_STAGES+1 cycles to take effect. The port then drives request high, still enabled, for one cycle. In the next cycle the request and ready enables drop, and acknowledge and strobe are enabled and driven high, while the data enable stays low for GAP_CYC cycles.
- R5: Request and acknowledge are never enabled together, and ready and data are never enabled together.
- R6: Each byte is taken from `tx_data` in a cycle that pulses `tx_taken`. It is driven with strobe high for one cycle, then with strobe low. Strobe returns high SYNC_STAGES+1 cycles after ready goes low, and the byte stays unchanged on the data outputs throughout.
- R7: After a word, the next strobe-low waits until the synchronized ready has returned high, even if `tx_valid` is already high.
- R8: A request-low input while the sender role is idle makes the port drive acknowledge low and release the data enable, SYNC_STAGES+1 cycles later. SYNC_STAGES+1 cycles after request returns high, every enable is low for one cycle. The port is then back in the receiver role as in R1.
- R9: Reset asserted in the sender role returns the port to the R1 state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_req_i | input | 1 | Request line as seen at the pad (active low) |
| lnk_rdy_i | input | 1 | Ready line as seen at the pad (active low) |
| lnk_ack_i | input | 1 | Acknowledge line as seen at the pad (active low) |
| lnk_stb_i | input | 1 | Strobe line as seen at the pad (active low) |
| lnk_dat_i | input | DATA_W | Data bus as seen at the pad |
| lnk_req_o | output | 1 | Request value to drive |
| lnk_req_oe | output | 1 | Request output enable |
| lnk_rdy_o | output | 1 | Ready value to drive |
| lnk_rdy_oe | output | 1 | Ready output enable |
| lnk_ack_o | output | 1 | Acknowledge value to drive |
| lnk_ack_oe | output | 1 | Acknowledge output enable |
| lnk_stb_o | output | 1 | Strobe value to drive |
| lnk_stb_oe | output | 1 | Strobe output enable |
| lnk_dat_o | output | DATA_W | Data value to drive |
| lnk_dat_oe | output | 1 | Data bus output enable |
| tx_valid | input | 1 | Local user has a byte to send |
| tx_data | input | DATA_W | Byte to send |
| tx_taken | output | 1 | One-cycle pulse: `tx_data` was latched |
| rx_valid | output | 1 | One-cycle pulse: a byte arrived |
| rx_data | output | DATA_W | Last received byte |

## Verification
The hardest situation to reach is the idle sender role after a complete exchange. Only from there can the far end ask for the token back, and only there can the R7 hold on the next word be seen. The bench reaches it by acting as the far end. It answers the request with acknowledge low and completes two words through the ready handshake. During the first word it keeps `tx_valid` high while ready is still low. It then pulls request low to reclaim the token. Every latency is counted edge by edge from the negedge at which the far-end input changes.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
   typedef enum logic [3:0] {
      IDLE_RX     = 4'd0,
      RX_BYTE     = 4'd1,
      TOKEN_ACK   = 4'd2,
      TURNAROUND  = 4'd3,
      TX_STROBE   = 4'd4,
      TX_WAIT_RDY = 4'd5,
      TX_DONE     = 4'd6,
      TOKEN_GIVE  = 4'd7,
      RX_RESUME   = 4'd8
   } tpl_state_e;
endpackage

// File: rtl/tpl_sync.sv
module tpl_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpl_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage[i] <= RST_VAL;
            else if (i == 0) stage[i] <= d;
            else stage[i] <= stage[(i > 0) ? i-1 : 0];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/tpl_ctrl.sv
module tpl_ctrl
   import tpl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int GAP_CYC = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb_s,
   input  logic              ack_s,
   input  logic              rdy_s,
   input  logic              req_s,
   input  logic [DATA_W-1:0] dat_s,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output tpl_state_e        state,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_taken,
   output logic [DATA_W-1:0] tx_byte
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

   tpl_state_e nxt;
   logic [GW-1:0] gap_cnt;
   logic          load_tx, load_rx;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("tpl_ctrl: GAP_CYC must be at least 1");
      end
   endgenerate

   always_comb begin
      nxt     = state;
      load_tx = 1'b0;
      load_rx = 1'b0;
      unique case (state)
         IDLE_RX: begin
            if (!stb_s) begin
               nxt = RX_BYTE;
               load_rx = 1'b1;
            end else if (tx_valid && !ack_s) begin
               nxt = TOKEN_ACK;
            end
         end
         RX_BYTE:    if (stb_s) nxt = IDLE_RX;
         TOKEN_ACK:  nxt = TURNAROUND;
         TURNAROUND: begin
            if (gap_cnt == GAP_LAST) begin
               if (tx_valid) begin
                  nxt = TX_STROBE;
                  load_tx = 1'b1;
               end else begin
                  nxt = TX_DONE;
               end
            end
         end
         TX_STROBE:   nxt = TX_WAIT_RDY;
         TX_WAIT_RDY: if (!rdy_s) nxt = TX_DONE;
         TX_DONE: begin
            if (rdy_s) begin
               if (tx_valid) begin
                  nxt = TX_STROBE;
                  load_tx = 1'b1;
               end else if (!req_s) begin
                  nxt = TOKEN_GIVE;
               end
            end
         end
         TOKEN_GIVE: if (req_s) nxt = RX_RESUME;
         RX_RESUME:  nxt = IDLE_RX;
         default:    nxt = IDLE_RX;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= IDLE_RX;
         gap_cnt  <= '0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         tx_taken <= 1'b0;
         tx_byte  <= '0;
      end else begin
         state    <= nxt;
         gap_cnt  <= (state == TURNAROUND && nxt == TURNAROUND) ? gap_cnt + 1'b1 : '0;
         rx_valid <= load_rx;
         tx_taken <= load_tx;
         if (load_rx) rx_data <= dat_s;
         if (load_tx) tx_byte <= tx_data;
      end
   end

   // R3
   rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);
endmodule

// File: rtl/tpl_pad.sv
module tpl_pad
   import tpl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  tpl_state_e        state,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              req_o,
   output logic              req_oe,
   output logic              rdy_o,
   output logic              rdy_oe,
   output logic              ack_o,
   output logic              ack_oe,
   output logic              stb_o,
   output logic              stb_oe,
   output logic [DATA_W-1:0] dat_o,
   output logic              dat_oe
);
   always_comb begin
      req_o = 1'b1; req_oe = 1'b0;
      rdy_o = 1'b1; rdy_oe = 1'b0;
      ack_o = 1'b1; ack_oe = 1'b0;
      stb_o = 1'b1; stb_oe = 1'b0;
      dat_o = tx_byte; dat_oe = 1'b0;
      unique case (state)
         IDLE_RX: begin
            req_oe = 1'b1; req_o = ~tx_valid;
            rdy_oe = 1'b1;
         end
         RX_BYTE: begin
            req_oe = 1'b1;
            rdy_oe = 1'b1; rdy_o = 1'b0;
         end
         TOKEN_ACK: begin
            req_oe = 1'b1;
            rdy_oe = 1'b1;
         end
         TURNAROUND: begin
            ack_oe = 1'b1;
            stb_oe = 1'b1;
         end
         TX_STROBE, TX_DONE: begin
            ack_oe = 1'b1;
            stb_oe = 1'b1;
            dat_oe = 1'b1;
         end
         TX_WAIT_RDY: begin
            ack_oe = 1'b1;
            stb_oe = 1'b1; stb_o = 1'b0;
            dat_oe = 1'b1;
         end
         TOKEN_GIVE: begin
            ack_oe = 1'b1; ack_o = 1'b0;
            stb_oe = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tpl_link_port.sv
module tpl_link_port
   import tpl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYC = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lnk_req_i,
   input  logic              lnk_rdy_i,
   input  logic              lnk_ack_i,
   input  logic              lnk_stb_i,
   input  logic [DATA_W-1:0] lnk_dat_i,
   output logic              lnk_req_o,
   output logic              lnk_req_oe,
   output logic              lnk_rdy_o,
   output logic              lnk_rdy_oe,
   output logic              lnk_ack_o,
   output logic              lnk_ack_oe,
   output logic              lnk_stb_o,
   output logic              lnk_stb_oe,
   output logic [DATA_W-1:0] lnk_dat_o,
   output logic              lnk_dat_oe,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_taken,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data
);
   localparam int CW = 4;

   logic [CW-1:0]     ctl_s;
   logic [DATA_W-1:0] dat_s;
   logic [DATA_W-1:0] tx_byte;
   tpl_state_e        state;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tpl_link_port: DATA_W must be positive");
      end
   endgenerate

   tpl_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctl_sync (
      .clk(clk), .rst(rst),
      .d({lnk_req_i, lnk_rdy_i, lnk_ack_i, lnk_stb_i}),
      .q(ctl_s)
   );

   tpl_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
      .clk(clk), .rst(rst), .d(lnk_dat_i), .q(dat_s)
   );

   tpl_ctrl #(.DATA_W(DATA_W), .GAP_CYC(GAP_CYC)) u_ctrl (
      .clk(clk), .rst(rst),
      .stb_s(ctl_s[0]), .ack_s(ctl_s[1]), .rdy_s(ctl_s[2]), .req_s(ctl_s[3]),
      .dat_s(dat_s), .tx_valid(tx_valid), .tx_data(tx_data),
      .state(state), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_taken(tx_taken), .tx_byte(tx_byte)
   );

   tpl_pad #(.DATA_W(DATA_W)) u_pad (
      .state(state), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .req_o(lnk_req_o), .req_oe(lnk_req_oe),
      .rdy_o(lnk_rdy_o), .rdy_oe(lnk_rdy_oe),
      .ack_o(lnk_ack_o), .ack_oe(lnk_ack_oe),
      .stb_o(lnk_stb_o), .stb_oe(lnk_stb_oe),
      .dat_o(lnk_dat_o), .dat_oe(lnk_dat_oe)
   );

   // R5
   req_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(lnk_req_oe && lnk_ack_oe));

   // R5
   rdy_dat_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(lnk_rdy_oe && lnk_dat_oe));

   // R4
   dat_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lnk_dat_oe) |-> ($past(lnk_ack_oe) && !$past(lnk_req_oe) && !$past(lnk_dat_oe)));

   // R6
   byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lnk_stb_oe && !lnk_stb_o && ctl_s[2]) |=> $stable(lnk_dat_o));

   // R3
   rx_rdy_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_valid) |-> !lnk_rdy_o);

   // R8
   give_release_chk: assert property (@(posedge clk) disable iff (rst)
      (lnk_ack_oe && !lnk_ack_o) |-> !lnk_dat_oe);
endmodule

// File: tb/tpl_link_port_tb.sv
module tpl_link_port_tb;
   localparam int DW = 8;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst;
   logic req_i, rdy_i, ack_i, stb_i;
   logic [DW-1:0] dat_i;
   logic req_o, req_oe, rdy_o, rdy_oe, ack_o, ack_oe, stb_o, stb_oe, dat_oe;
   logic [DW-1:0] dat_o;
   logic tx_valid, tx_taken, rx_valid;
   logic [DW-1:0] tx_data, rx_data;
   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   tpl_link_port u_dut (
      .clk(clk), .rst(rst),
      .lnk_req_i(req_i), .lnk_rdy_i(rdy_i), .lnk_ack_i(ack_i), .lnk_stb_i(stb_i),
      .lnk_dat_i(dat_i),
      .lnk_req_o(req_o), .lnk_req_oe(req_oe), .lnk_rdy_o(rdy_o), .lnk_rdy_oe(rdy_oe),
      .lnk_ack_o(ack_o), .lnk_ack_oe(ack_oe), .lnk_stb_o(stb_o), .lnk_stb_oe(stb_oe),
      .lnk_dat_o(dat_o), .lnk_dat_oe(dat_oe),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_taken(tx_taken),
      .rx_valid(rx_valid), .rx_data(rx_data)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_rx_role(input string req);
      chk(req, "receiver pins {req,req_oe,rdy,rdy_oe,ack_oe,stb_oe,dat_oe}",
          {req_o, req_oe, rdy_o, rdy_oe, ack_oe, stb_oe, dat_oe}, 7'b1111000);
   endtask

   task automatic t_reset;
      chk_rx_role("R1");
      chk("R1", "rx_valid/tx_taken", {rx_valid, tx_taken}, 2'b00);
   endtask

   task automatic t_receive(input logic [DW-1:0] b);
      dat_i = b; stb_i = 1'b0;
      tick(LAT - 1);
      chk("R3", "ready before sync latency", rdy_o, 1'b1);
      tick(1);
      chk("R3", "ready low", {rdy_oe, rdy_o}, 2'b10);
      chk("R3", "rx_valid pulse", rx_valid, 1'b1);
      chk("R3", "rx_data", rx_data, b);
      tick(1);
      chk("R3", "rx_valid single cycle", rx_valid, 1'b0);
      stb_i = 1'b1;
      tick(LAT);
      chk("R3", "ready back high", rdy_o, 1'b1);
   endtask

   task automatic t_token_and_send;
      tx_valid = 1'b1; tx_data = 8'h81;
      tick(1);
      chk("R2", "request low", {req_oe, req_o}, 2'b10);
      ack_i = 1'b0;
      tick(LAT - 1);
      chk("R4", "request still low", req_o, 1'b0);
      tick(1);
      chk("R4", "request driven high", {req_oe, req_o, ack_oe}, 3'b110);
      tick(1);
      ack_i = 1'b1;
      chk("R4", "turnaround {req_oe,rdy_oe,ack_oe,ack,stb_oe,stb,dat_oe}",
          {req_oe, rdy_oe, ack_oe, ack_o, stb_oe, stb_o, dat_oe}, 7'b0011110);
      tick(1);
      chk("R6", "byte setup {dat_oe,stb,taken}", {dat_oe, stb_o, tx_taken}, 3'b111);
      chk("R6", "first byte", dat_o, 8'h81);
      tx_data = 8'h42;
      tick(1);
      chk("R6", "strobe low", {stb_oe, stb_o}, 2'b10);
      tick(3);
      chk("R6", "byte held while ready high", {dat_o, stb_o}, {8'h81, 1'b0});
      rdy_i = 1'b0;
      tick(LAT - 1);
      chk("R6", "strobe still low", stb_o, 1'b0);
      tick(1);
      chk("R6", "strobe back high, byte held", {stb_o, dat_o}, {1'b1, 8'h81});
      tick(2);
      chk("R7", "no new word while ready low", {stb_o, tx_taken}, 2'b10);
      rdy_i = 1'b1;
      tick(LAT);
      chk("R7", "second byte after ready high", {tx_taken, dat_o}, {1'b1, 8'h42});
      tx_valid = 1'b0;
      tick(1);
      chk("R6", "second strobe low", stb_o, 1'b0);
      rdy_i = 1'b0;
      tick(LAT);
      chk("R6", "second strobe high", stb_o, 1'b1);
      rdy_i = 1'b1;
      tick(LAT + 1);
      chk("R6", "idle sender keeps pins", {ack_oe, ack_o, stb_o, dat_oe}, 4'b1111);
   endtask

   task automatic t_give_back;
      req_i = 1'b0;
      tick(LAT);
      chk("R8", "ack low, data released {ack_oe,ack,dat_oe}",
          {ack_oe, ack_o, dat_oe}, 3'b100);
      req_i = 1'b1;
      tick(LAT);
      chk("R8", "all enables low", {req_oe, rdy_oe, ack_oe, stb_oe, dat_oe}, 5'b0);
      tick(1);
      chk_rx_role("R8");
   endtask

   task automatic t_reset_in_tx;
      tx_valid = 1'b1; tx_data = 8'h5A;
      tick(1);
      ack_i = 1'b0;
      tick(LAT + 3);
      ack_i = 1'b1;
      chk("R9", "in sender role", {dat_oe, dat_o}, {1'b1, 8'h5A});
      tx_valid = 1'b0;
      rst = 1'b1;
      tick(1);
      chk_rx_role("R9");
      rst = 1'b0;
   endtask

   initial begin
      rst = 1'b1;
      req_i = 1'b1; rdy_i = 1'b1; ack_i = 1'b1; stb_i = 1'b1; dat_i = '0;
      tx_valid = 1'b0; tx_data = '0;
      tick(3);
      rst = 1'b0;
      t_reset();
      t_receive(8'hA5);
      t_receive(8'h3C);
      t_token_and_send();
      t_give_back();
      t_receive(8'hC3);
      t_reset_in_tx();
      t_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule